// File: doc/BRIEF.md
# Communication Watchdog and Reset Supervisor

This block supervises a field-bus slave interface. It watches the falling edges of two sensed strobe pins: a data-port strobe and a parameter-port strobe. When these transfers stop for longer than a timeout, it issues a soft reset. A soft reset also comes from a reset-slave or reset-broadcast command pulse, and from an outside agent holding the data strobe pin low for too long. Each soft reset produces a one-cycle `softRst` pulse. It also asks for all port drivers to be switched off, and it pulls both strobe pins low together for a fixed number of cycles.

A hard reset comes from two supply-good flags. It clears every register in the block. A soft reset leaves the watchdog state and the blink timer running. The block also drives a green and a red status indicator. A fixed priority of conditions selects the indicator pattern, and a free-running blink timer paces the blinking.

All time windows are counted in system-clock cycles and set by parameters. The default values target a 200 MHz clock: a 75 ms watchdog window, an 80 ms long-low window, a 6 us strobe pulse and a 2.5 Hz blink.

Top module: `commwd_supervisor`

## Requirements
- R1: `hardRst` is 1 at once (asynchronously) whenever `pwr5Good` is 0. It goes to 0 on the first clock edge at which `pwr5Good` and `pwr24Good` are both 1. After that it stays 0 as long as `pwr5Good` stays 1.
- R2: With `pwr5Good` at 1, a drop of `pwr24Good` causes no hard reset. An armed watchdog still expires and gives a soft reset.
- R3: A falling edge on either sensed strobe arms the watchdog and restarts its count. If no further edge arrives, `softRst` is 1 in the cycle after exactly WDOG_CYCLES clock edges. The count starts at the edge that sampled the strobe low. Without a new edge, the watchdog fires only once.
- R4: While `wdogDisable` is 1, the watchdog never fires.
- R5: The data strobe pin can be held low from outside, with the block not driving it. If it is sampled low on LONG_LOW_CYCLES consecutive edges, a soft reset follows: `softRst` is 1 right after the last of these edges. One sample fewer gives no soft reset.
- R6: A one-cycle pulse on `cmdResetSlave` gives `softRst`=1 in the next cycle. A pulse on `cmdResetBcast` does the same.
- R7: Each soft reset makes `softRst` 1 for one cycle, with `portsOff` 1 in that cycle. From that same cycle, `dStrobeDrv` and `pStrobeDrv` are both 1 (pin pulled low) for exactly STROBE_CYCLES cycles. Several sources firing in the same cycle give only one such pulse.
- R8: A soft reset neither restarts nor disarms the watchdog, and it does not disturb the blink timer. After a command reset in the middle of a window, the watchdog still fires WDOG_CYCLES edges after the last strobe edge.
- R9: Outside hard reset, the output pair {greenOn, redOn} follows this priority, highest first:
  - Strobe held low past the long-low limit (until the pin reads high again), or `railOverload`=1: {0, blink}.
  - `periphFaultN`=0: {blink, ~blink}.
  - `addrZero`=1: {blink, 1}.
  - Watchdog tripped and no strobe edge since: {0, 1}.
  - Otherwise: {1, 0}.
- R10: The blink phase starts at 0 on the first edge after hard-reset release. It toggles every BLINK_HALF_CYCLES edges, so after the k-th edge since release it equals (k / BLINK_HALF_CYCLES) mod 2.
- R11: During hard reset, `greenOn`, `redOn`, `dStrobeDrv` and `pStrobeDrv` are 0, and `portsOff` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr5Good | input | 1 | Logic supply above threshold; low starts hard reset asynchronously |
| pwr24Good | input | 1 | Field supply above threshold; needed to leave hard reset |
| dStrobeIn | input | 1 | Sensed data strobe pin level (0 = low) |
| pStrobeIn | input | 1 | Sensed parameter strobe pin level (0 = low) |
| cmdResetSlave | input | 1 | One-cycle pulse: reset-slave command decoded |
| cmdResetBcast | input | 1 | One-cycle pulse: reset-broadcast command decoded |
| wdogDisable | input | 1 | 1 stops the watchdog from firing |
| periphFaultN | input | 1 | Peripheral fault flag, active low |
| addrZero | input | 1 | 1 when the slave address is zero |
| railOverload | input | 1 | 1 when the field supply output is switched off for overload |
| hardRst | output | 1 | Hard reset condition |
| softRst | output | 1 | One-cycle soft reset pulse |
| portsOff | output | 1 | Switch off all port output drivers |
| dStrobeDrv | output | 1 | 1 pulls the data strobe pin low |
| pStrobeDrv | output | 1 | 1 pulls the parameter strobe pin low |
| greenOn | output | 1 | Green indicator on |
| redOn | output | 1 | Red indicator on |

## Verification
Four soft-reset sources can fire in the same cycle: watchdog expiry, the long-low detector and the two command inputs. The sharpest case is a command pulse landing on the very edge at which the watchdog expires. The bench counts cycles from a strobe edge and raises `cmdResetBcast` on exactly the expiry edge. The result is judged on the outputs: `softRst` must be high for only one cycle, and each strobe drive must be high for exactly STROBE_CYCLES cycles, not twice that. The blink timer also runs across command resets placed inside a watchdog window. The green output is compared on every cycle with the phase predicted from the cycle count since release.

// File: rtl/commwd_pkg.sv
`timescale 1ns/1ps
package commwd_pkg;
  // Control to datapath: one-cycle strobes and run levels
  typedef struct packed {
    logic wdogRestart;
    logic wdogRun;
    logic lowRun;
    logic pulseStart;
  } dpCmd_t;

  // Datapath to control: timer events and levels
  typedef struct packed {
    logic wdogExpired;
    logic lowHit;
    logic blinkPhase;
    logic pulseActive;
  } dpStat_t;
endpackage

// File: rtl/commwd_dp.sv
`timescale 1ns/1ps
module commwd_dp
  import commwd_pkg::*;
#(
  parameter int WDOG_CYCLES       = 15_000_000,
  parameter int LONG_LOW_CYCLES   = 16_000_000,
  parameter int STROBE_CYCLES     = 1_200,
  parameter int BLINK_HALF_CYCLES = 40_000_000
) (
  input  logic    clk,
  input  logic    pwr5Good,
  input  logic    hardRst,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);
  localparam int WDOG_W  = $clog2(WDOG_CYCLES + 1);
  localparam int LOW_W   = $clog2(LONG_LOW_CYCLES + 1);
  localparam int PULSE_W = $clog2(STROBE_CYCLES + 1);
  localparam int BLINK_W = $clog2(BLINK_HALF_CYCLES + 1);
  localparam logic [WDOG_W-1:0]  WDOG_LAST  = WDOG_W'(WDOG_CYCLES - 1);
  localparam logic [LOW_W-1:0]   LOW_LAST   = LOW_W'(LONG_LOW_CYCLES - 1);
  localparam logic [LOW_W-1:0]   LOW_SAT    = LOW_W'(LONG_LOW_CYCLES);
  localparam logic [PULSE_W-1:0] PULSE_LEN  = PULSE_W'(STROBE_CYCLES);
  localparam logic [BLINK_W-1:0] BLINK_LAST = BLINK_W'(BLINK_HALF_CYCLES - 1);

  logic [WDOG_W-1:0]  wdogCnt;
  logic [LOW_W-1:0]   lowCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic [BLINK_W-1:0] blinkCnt;
  logic               blinkPhase;

  // Watchdog window counter: restarted by any strobe edge, holds when idle
  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good)            wdogCnt <= '0;
    else if (hardRst)         wdogCnt <= '0;
    else if (cmd.wdogRestart) wdogCnt <= '0;
    else if (cmd.wdogRun && wdogCnt != WDOG_LAST) wdogCnt <= wdogCnt + 1'b1;
  end

  // Long-low counter on the externally held data strobe, saturating
  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good)            lowCnt <= '0;
    else if (hardRst)         lowCnt <= '0;
    else if (!cmd.lowRun)     lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  // Strobe pulse length counter
  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good)           pulseCnt <= '0;
    else if (hardRst)        pulseCnt <= '0;
    else if (cmd.pulseStart) pulseCnt <= PULSE_LEN;
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  // Free-running blink timer, untouched by soft reset
  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (hardRst) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (blinkCnt == BLINK_LAST) begin
      blinkCnt   <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      blinkCnt   <= blinkCnt + 1'b1;
    end
  end

  always_comb begin
    stat.wdogExpired = cmd.wdogRun && !cmd.wdogRestart && (wdogCnt == WDOG_LAST);
    stat.lowHit      = cmd.lowRun && (lowCnt == LOW_LAST);
    stat.blinkPhase  = blinkPhase;
    stat.pulseActive = (pulseCnt != '0);
  end
endmodule

// File: rtl/commwd_ctrl.sv
`timescale 1ns/1ps
module commwd_ctrl
  import commwd_pkg::*;
(
  input  logic    clk,
  input  logic    pwr5Good,
  input  logic    pwr24Good,
  input  logic    dStrobeIn,
  input  logic    pStrobeIn,
  input  logic    cmdResetSlave,
  input  logic    cmdResetBcast,
  input  logic    wdogDisable,
  input  logic    periphFaultN,
  input  logic    addrZero,
  input  logic    railOverload,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    hardRst,
  output logic    softRst,
  output logic    portsOff,
  output logic    strobeDrv,
  output logic    greenOn,
  output logic    redOn
);
  logic       running;
  logic [1:0] pinNow;
  logic [1:0] pinPrev;
  logic [1:0] fallSeen;
  logic       anyEdge;
  logic       softSrc;
  logic       armed;
  logic       tripped;
  logic       extHeld;

  // Hard reset: 5 V flag low clears at once, release needs both flags
  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good)      running <= 1'b0;
    else if (pwr24Good) running <= 1'b1;
  end
  assign hardRst = !running;

  assign strobeDrv = running && stat.pulseActive;
  assign pinNow    = {pStrobeIn, dStrobeIn};
  // Own strobe pulses are not counted as traffic
  assign fallSeen  = pinPrev & ~pinNow & {2{~strobeDrv}};
  assign anyEdge   = |fallSeen;
  assign softSrc   = cmdResetSlave | cmdResetBcast | stat.wdogExpired | stat.lowHit;

  always_comb begin
    cmd.wdogRestart = anyEdge;
    cmd.wdogRun     = armed && !wdogDisable;
    cmd.lowRun      = running && !dStrobeIn && !strobeDrv;
    cmd.pulseStart  = running && softSrc;
  end

  always_ff @(posedge clk or negedge pwr5Good) begin
    if (!pwr5Good) begin
      pinPrev <= 2'b11;
      armed   <= 1'b0;
      tripped <= 1'b0;
      extHeld <= 1'b0;
      softRst <= 1'b0;
    end else if (hardRst) begin
      pinPrev <= 2'b11;
      armed   <= 1'b0;
      tripped <= 1'b0;
      extHeld <= 1'b0;
      softRst <= 1'b0;
    end else begin
      pinPrev <= pinNow;
      softRst <= softSrc;
      if (anyEdge)               armed <= 1'b1;
      else if (stat.wdogExpired) armed <= 1'b0;
      if (anyEdge)               tripped <= 1'b0;
      else if (stat.wdogExpired) tripped <= 1'b1;
      if (stat.lowHit)           extHeld <= 1'b1;
      else if (dStrobeIn)        extHeld <= 1'b0;
    end
  end

  assign portsOff = hardRst | softRst;

  // Indicator priority table
  always_comb begin
    if (hardRst) begin
      greenOn = 1'b0;
      redOn   = 1'b0;
    end else if (extHeld || railOverload) begin
      greenOn = 1'b0;
      redOn   = stat.blinkPhase;
    end else if (!periphFaultN) begin
      greenOn = stat.blinkPhase;
      redOn   = !stat.blinkPhase;
    end else if (addrZero) begin
      greenOn = stat.blinkPhase;
      redOn   = 1'b1;
    end else if (tripped) begin
      greenOn = 1'b0;
      redOn   = 1'b1;
    end else begin
      greenOn = 1'b1;
      redOn   = 1'b0;
    end
  end
endmodule

// File: rtl/commwd_supervisor.sv
`timescale 1ns/1ps
module commwd_supervisor
  import commwd_pkg::*;
#(
  parameter int WDOG_CYCLES       = 15_000_000,
  parameter int LONG_LOW_CYCLES   = 16_000_000,
  parameter int STROBE_CYCLES     = 1_200,
  parameter int BLINK_HALF_CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic pwr5Good,
  input  logic pwr24Good,
  input  logic dStrobeIn,
  input  logic pStrobeIn,
  input  logic cmdResetSlave,
  input  logic cmdResetBcast,
  input  logic wdogDisable,
  input  logic periphFaultN,
  input  logic addrZero,
  input  logic railOverload,
  output logic hardRst,
  output logic softRst,
  output logic portsOff,
  output logic dStrobeDrv,
  output logic pStrobeDrv,
  output logic greenOn,
  output logic redOn
);
  dpCmd_t  dpCmd;
  dpStat_t dpStat;
  logic    strobeDrv;

  commwd_ctrl u_ctrl (
    .clk(clk), .pwr5Good(pwr5Good), .pwr24Good(pwr24Good),
    .dStrobeIn(dStrobeIn), .pStrobeIn(pStrobeIn),
    .cmdResetSlave(cmdResetSlave), .cmdResetBcast(cmdResetBcast),
    .wdogDisable(wdogDisable), .periphFaultN(periphFaultN),
    .addrZero(addrZero), .railOverload(railOverload),
    .stat(dpStat), .cmd(dpCmd), .hardRst(hardRst), .softRst(softRst),
    .portsOff(portsOff), .strobeDrv(strobeDrv),
    .greenOn(greenOn), .redOn(redOn)
  );

  commwd_dp #(
    .WDOG_CYCLES(WDOG_CYCLES), .LONG_LOW_CYCLES(LONG_LOW_CYCLES),
    .STROBE_CYCLES(STROBE_CYCLES), .BLINK_HALF_CYCLES(BLINK_HALF_CYCLES)
  ) u_dp (
    .clk(clk), .pwr5Good(pwr5Good), .hardRst(hardRst),
    .cmd(dpCmd), .stat(dpStat)
  );

  assign dStrobeDrv = strobeDrv;
  assign pStrobeDrv = strobeDrv;
endmodule

// File: rtl/commwd_checker.sv
`timescale 1ns/1ps
module commwd_checker (
  input logic clk,
  input logic pwr5Good,
  input logic hardRst,
  input logic softRst,
  input logic dStrobeDrv,
  input logic pStrobeDrv,
  input logic greenOn,
  input logic redOn,
  input logic railOverload,
  input logic periphFaultN,
  input logic dStrobeIn
);
  assert_hard_hold_R1: assert property (@(posedge clk)
    !pwr5Good |-> hardRst);

  assert_soft_strobes_R7: assert property (@(posedge clk) disable iff (hardRst)
    softRst |-> (dStrobeDrv && pStrobeDrv));

  assert_strobe_origin_R7: assert property (@(posedge clk) disable iff (hardRst)
    $rose(dStrobeDrv) |-> softRst);

  assert_dark_in_reset_R11: assert property (@(posedge clk)
    hardRst |-> (!greenOn && !redOn && !dStrobeDrv));

  assert_overload_green_R9: assert property (@(posedge clk) disable iff (hardRst)
    railOverload |-> !greenOn);

  assert_fault_alternate_R9: assert property (@(posedge clk) disable iff (hardRst)
    (!railOverload && !periphFaultN && dStrobeIn && $past(dStrobeIn)) |-> (greenOn != redOn));
endmodule

bind commwd_supervisor commwd_checker u_chk (
  .clk(clk), .pwr5Good(pwr5Good), .hardRst(hardRst), .softRst(softRst),
  .dStrobeDrv(dStrobeDrv), .pStrobeDrv(pStrobeDrv), .greenOn(greenOn),
  .redOn(redOn), .railOverload(railOverload), .periphFaultN(periphFaultN),
  .dStrobeIn(dStrobeIn)
);

// File: tb/commwd_supervisor_tb.sv
`timescale 1ns/1ps
module commwd_supervisor_tb;
  localparam int W  = 200;
  localparam int L  = 150;
  localparam int S  = 6;
  localparam int BH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic pwr5Good = 1'b0, pwr24Good = 1'b0;
  logic cmdResetSlave = 1'b0, cmdResetBcast = 1'b0, wdogDisable = 1'b0;
  logic periphFaultN = 1'b1, addrZero = 1'b0, railOverload = 1'b0;
  logic dExt = 1'b0, pExt = 1'b0;
  logic dStrobeIn, pStrobeIn;
  logic hardRst, softRst, portsOff, dStrobeDrv, pStrobeDrv, greenOn, redOn;

  assign dStrobeIn = ~(dExt | dStrobeDrv);
  assign pStrobeIn = ~(pExt | pStrobeDrv);

  commwd_supervisor #(
    .WDOG_CYCLES(W), .LONG_LOW_CYCLES(L), .STROBE_CYCLES(S), .BLINK_HALF_CYCLES(BH)
  ) u_dut (
    .clk(clk), .pwr5Good(pwr5Good), .pwr24Good(pwr24Good),
    .dStrobeIn(dStrobeIn), .pStrobeIn(pStrobeIn),
    .cmdResetSlave(cmdResetSlave), .cmdResetBcast(cmdResetBcast),
    .wdogDisable(wdogDisable), .periphFaultN(periphFaultN),
    .addrZero(addrZero), .railOverload(railOverload),
    .hardRst(hardRst), .softRst(softRst), .portsOff(portsOff),
    .dStrobeDrv(dStrobeDrv), .pStrobeDrv(pStrobeDrv),
    .greenOn(greenOn), .redOn(redOn)
  );

  int errors = 0, checks = 0;
  int softCnt = 0, dDrvCnt = 0, pDrvCnt = 0;
  int k = 0;

  // edges since hard-reset release, for the expected blink phase
  always @(posedge clk) k <= hardRst ? 0 : k + 1;

  always @(negedge clk) begin
    if (softRst)    softCnt++;
    if (dStrobeDrv) dDrvCnt++;
    if (pStrobeDrv) pDrvCnt++;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phase();
    return (k / BH) % 2;
  endfunction

  function automatic logic [1:0] expLed(logic rail, logic faultN, logic az, logic trip, logic ext, logic ph);
    if (rail || ext)  return {1'b0, ph};
    else if (!faultN) return {ph, ~ph};
    else if (az)      return {ph, 1'b1};
    else if (trip)    return 2'b01;
    else              return 2'b10;
  endfunction

  task automatic edgeD();
    dExt = 1'b1; step(); dExt = 1'b0;
  endtask

  task automatic edgeP();
    pExt = 1'b1; step(); pExt = 1'b0;
  endtask

  task automatic hardReset();
    pwr5Good = 1'b0; dExt = 1'b0; pExt = 1'b0;
    cmdResetSlave = 1'b0; cmdResetBcast = 1'b0; wdogDisable = 1'b0;
    addrZero = 1'b0; railOverload = 1'b0; periphFaultN = 1'b1;
    step();
    pwr5Good = 1'b1; pwr24Good = 1'b1;
    step();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    finishRun();
  end

  initial begin
    int s0, d0, p0, firedAt, gap, blinkBad, hadHard;
    logic [1:0] e;
    void'($urandom(32'd4242));

    // R11 / R1: reset state
    step(); step();
    check("R11 hardRst in reset", int'(hardRst), 1);
    check("R11 leds dark", int'({greenOn, redOn}), 0);
    check("R11 portsOff", int'(portsOff), 1);
    check("R11 strobe drive idle", int'(dStrobeDrv | pStrobeDrv), 0);
    pwr5Good = 1'b1;
    repeat (3) step();
    check("R1 held without 24V", int'(hardRst), 1);
    pwr24Good = 1'b1; step();
    check("R1 released", int'(hardRst), 0);
    check("R9 normal leds", int'({greenOn, redOn}), 2);
    pwr5Good = 1'b0; #1;
    check("R1 async entry", int'(hardRst), 1);
    step(); pwr5Good = 1'b1; step();
    check("R1 re-release", int'(hardRst), 0);

    // R2: 24V drop alone
    edgeD();
    pwr24Good = 1'b0; s0 = softCnt; hadHard = 0;
    repeat (W + 10) begin step(); if (hardRst) hadHard = 1; end
    check("R2 no hard reset", hadHard, 0);
    check("R2 watchdog soft reset", softCnt - s0, 1);
    pwr24Good = 1'b1;

    // R6 / R7: command resets
    hardReset();
    s0 = softCnt; d0 = dDrvCnt; p0 = pDrvCnt;
    cmdResetSlave = 1'b1; step(); cmdResetSlave = 1'b0;
    check("R6 reset-slave", int'(softRst), 1);
    check("R7 portsOff with soft", int'(portsOff), 1);
    repeat (20) step();
    check("R7 single pulse", softCnt - s0, 1);
    check("R7 data strobe width", dDrvCnt - d0, S);
    check("R7 param strobe width", pDrvCnt - p0, S);
    s0 = softCnt;
    cmdResetBcast = 1'b1; step(); cmdResetBcast = 1'b0;
    check("R6 reset-broadcast", int'(softRst), 1);
    step();
    check("R7 one cycle", int'(softRst), 0);

    // R3: exact expiry and tripped indicator
    hardReset();
    edgeD();
    repeat (W - 1) step();
    check("R3 not before window", int'(softRst), 0);
    step();
    check("R3 fires at window", int'(softRst), 1);
    step();
    check("R9 tripped leds", int'({greenOn, redOn}), 1);

    // R3: the other strobe restarts the window
    hardReset();
    edgeD();
    repeat (W / 2) step();
    edgeP();
    repeat (W - 1) step();
    check("R3 restarted by param strobe", int'(softRst), 0);
    step();
    check("R3 fires after param edge", int'(softRst), 1);

    // R3: random gaps
    hardReset();
    for (int t = 0; t < 8; t++) begin
      gap = $urandom_range(20, 2 * W);
      if (gap > W - 10 && gap < W + 20) gap = W + 20;
      if ($urandom % 2) edgeD(); else edgeP();
      firedAt = 0;
      for (int j = 1; j <= gap; j++) begin
        step();
        if (softRst && firedAt == 0) firedAt = j;
      end
      check("R3 random gap", firedAt, (gap >= W) ? W : 0);
    end

    // R4: disabled watchdog
    hardReset();
    edgeD();
    wdogDisable = 1'b1; s0 = softCnt;
    repeat (2 * W) step();
    check("R4 disabled no fire", softCnt - s0, 0);

    // R8 / R10: soft reset inside window, blink continuity
    hardReset();
    addrZero = 1'b1;
    edgeD();
    s0 = softCnt; blinkBad = 0;
    for (int j = 1; j <= W - 1; j++) begin
      cmdResetSlave = (j == 50 || j == 120);
      step();
      if (greenOn !== phase()) blinkBad++;
    end
    cmdResetSlave = 1'b0;
    check("R8 watchdog kept running", int'(softRst), 0);
    step();
    check("R8 fires on original window", int'(softRst), 1);
    check("R8 three soft resets", softCnt - s0, 3);
    check("R10 blink phase across soft resets", blinkBad, 0);

    // Concurrent: command on the expiry edge
    hardReset();
    edgeD();
    repeat (W - 1) step();
    s0 = softCnt; d0 = dDrvCnt; p0 = pDrvCnt;
    cmdResetBcast = 1'b1; step(); cmdResetBcast = 1'b0;
    check("R7 merged soft reset", int'(softRst), 1);
    repeat (20) step();
    check("R7 merged single pulse", softCnt - s0, 1);
    check("R7 merged strobe width", dDrvCnt - d0, S);
    check("R7 merged param width", pDrvCnt - p0, S);

    // R5: long low
    hardReset();
    wdogDisable = 1'b1; s0 = softCnt;
    dExt = 1'b1;
    repeat (L - 5) step();
    dExt = 1'b0; step();
    check("R5 short low ignored", softCnt - s0, 0);
    dExt = 1'b1;
    for (int j = 1; j <= L + 5; j++) begin
      step();
      if (j == L - 1) check("R5 not before limit", int'(softRst), 0);
      if (j == L)     check("R5 fires at limit", int'(softRst), 1);
      if (j == L + 1) check("R9 held strobe leds", int'({greenOn, redOn}), int'({1'b0, phase() == 1}));
    end
    dExt = 1'b0; step(); step();
    check("R5 single long-low reset", softCnt - s0, 1);
    check("R9 held indication cleared", int'({greenOn, redOn}), 2);

    // R9 random priority, watchdog not tripped then tripped
    hardReset();
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        edgeD();
        repeat (W + 2) step();
      end
      for (int t = 0; t < 60; t++) begin
        railOverload = ($urandom % 4) == 0;
        periphFaultN = ($urandom % 3) != 0;
        addrZero     = ($urandom % 3) == 0;
        #1;
        e = expLed(railOverload, periphFaultN, addrZero, pass == 1, 1'b0, phase() == 1);
        check("R9 priority table", int'({greenOn, redOn}), int'(e));
        step();
      end
    end

    finishRun();
  end
endmodule